// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block takes stereo audio from a three-wire serial port and turns each channel word into a 24-bit parallel two's complement sample. The three wires are a bit clock, a frame clock that splits every frame into a left and a right half, and a data line. All logic runs on the master clock. The bit clock and frame clock are oversampled on that clock and their edges are found from the synchronized levels.

A two-bit format code selects the framing. Right-justified modes slide every bit of the half-frame through a shift register and keep the newest 16 or 24 bits. Left-justified and I2S modes place bits from the most significant end, starting at a fixed offset from the frame-clock change. Words shorter than 24 bits are filled with zeros at the bottom.

A finished stereo pair comes out with a single-cycle strobe. Two sticky flags report problems. The first says a half-frame was too short for the selected word length. The second says the master clock did not run exactly 256 cycles per frame.

Top module: `audio_serial_rx`

## Requirements
- R1: The format code is taken from `fmt_sel` only in the first master-clock cycle after reset is released and while `standby` is high. A change of `fmt_sel` at any other time has no effect on how data is decoded.
- R2: Code 2'b10 selects left-justified framing. A high frame clock marks the left half-frame. The MSB is the bit taken on the first bit-clock rising edge after the frame-clock change. Bits are placed from bit 23 downward, and positions beyond the half-frame's bit count read as zero.
- R3: Code 2'b11 selects I2S framing. A low frame clock marks the left half-frame. The MSB is taken one bit clock after the frame-clock change. The word's last bit may fall on the first bit clock of the following half-frame. Placement and zero fill follow R2.
- R4: Code 2'b00 selects right-justified 16-bit framing, with a high frame clock marking left. The sample is the last 16 bits of the half-frame, sign-extended from bit 15 to 24 bits. Earlier bits of the half-frame are ignored.
- R5: Code 2'b01 selects right-justified 24-bit framing, with a high frame clock marking left. The sample is the last 24 bits of the half-frame.
- R6: Data is sampled on bit-clock rising edges, MSB first. Each left/right pair is presented together on `left_sample` and `right_sample` with `sample_valid` high for exactly one master-clock cycle. This happens after the right word is closed by the next frame-clock change.
- R7: `short_frame_err` is set when a completed half-frame holds fewer bit-clock rising edges than the minimum word length. The minimum is 24 for code 2'b01 and 16 for the other codes. The flag stays set until reset or standby.
- R8: `mclk_ratio_err` is set when two consecutive rising edges of the frame clock are not exactly 256 master-clock cycles apart. The flag stays set until reset or standby.
- R9: After reset, both samples are zero and `sample_valid` and both flags are low.
- R10: The block decodes nothing until it has seen a frame-clock change after wake-up, so a constant frame clock gives no strobe. While `standby` is high, the samples and flags are cleared and no strobe is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 256 times the frame rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby | input | 1 | Holds the block idle and lets it take a new format code |
| fmt_sel | input | 2 | Framing code, used at wake-up only |
| bclk_in | input | 1 | Serial bit clock |
| lrclk_in | input | 1 | Frame (left/right) clock |
| sdata_in | input | 1 | Serial data, MSB first, two's complement |
| left_sample | output | 24 | Left channel sample |
| right_sample | output | 24 | Right channel sample |
| sample_valid | output | 1 | One-cycle strobe for a new stereo pair |
| short_frame_err | output | 1 | Sticky flag for a half-frame too short for the word |
| mclk_ratio_err | output | 1 | Sticky flag for a master-clock/frame ratio other than 256 |

## Verification
The hardest case to reach is I2S at the minimum bit-clock count. There, the LSB of every word arrives on the first bit clock of the next half-frame and must be merged into the word being closed. The bench reaches it by building its streams as a left-justified stream delayed by one bit slot, and by setting the bit-clock period in master-clock cycles to give 16-slot halves. The frame-ratio flag needs a bit clock whose period does not divide into 256 master clocks per frame. A 5-cycle bit period provides this, while the right-justified tests fill the unused leading slots with ones to show they are discarded.

// File: rtl/asr_pkg.sv
package asr_pkg;

  localparam int SAMPLE_W = 24;

  typedef enum logic [1:0] {
    FMT_RJ16 = 2'b00,
    FMT_RJ24 = 2'b01,
    FMT_LJ   = 2'b10,
    FMT_I2S  = 2'b11
  } fmt_e;

  // Smallest legal half-frame length, in bit clocks.
  function automatic int min_bits(fmt_e f);
    return (f == FMT_RJ24) ? 24 : 16;
  endfunction

  // Frame clock level that marks the left channel.
  function automatic logic left_level(fmt_e f);
    return (f == FMT_I2S) ? 1'b0 : 1'b1;
  endfunction

  function automatic logic is_rj(fmt_e f);
    return (f == FMT_RJ16) || (f == FMT_RJ24);
  endfunction

  // Take the newest bits of the sliding register as a sample.
  function automatic logic [SAMPLE_W-1:0] rj_word(logic [SAMPLE_W-1:0] sr, fmt_e f);
    if (f == FMT_RJ16) return {{8{sr[15]}}, sr[15:0]};
    return sr;
  endfunction

  // Write one bit at position pos counted from the MSB; beyond 24 it drops.
  function automatic logic [SAMPLE_W-1:0] put_bit(logic [SAMPLE_W-1:0] acc,
                                                  logic [15:0] pos, logic b);
    logic [SAMPLE_W-1:0] r;
    logic [4:0] idx;
    r = acc;
    if (pos < 16'(SAMPLE_W)) begin
      idx = 5'(16'(SAMPLE_W - 1) - pos);
      r[idx] = b;
    end
    return r;
  endfunction

  // Frame period check: cnt holds cycles since the previous edge minus one.
  function automatic logic period_ok(int unsigned cnt, int unsigned ratio);
    return cnt == ratio - 1;
  endfunction

endpackage

// File: rtl/asr_sync.sv
module asr_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         ready
);

  logic [W-1:0] pipe [STAGES];
  logic [STAGES:0] rdy_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
      rdy_sr <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      rdy_sr <= {rdy_sr[STAGES-1:0], 1'b1};
    end
  end

  assign q     = pipe[STAGES-1];
  assign ready = rdy_sr[STAGES];

endmodule

// File: rtl/asr_deframer.sv
module asr_deframer
  import asr_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  fmt_e                fmt,
  input  logic                bit_rise,
  input  logic                lr_bit,
  input  logic                sd_bit,
  output logic                word_done,
  output logic                word_left,
  output logic [SAMPLE_W-1:0] word_data,
  output logic                word_short
);

  logic                primed;
  logic                aligned;
  logic                lr_last;
  logic [CNT_W-1:0]    cnt;
  logic [SAMPLE_W-1:0] acc;
  logic [SAMPLE_W-1:0] sr;
  logic [SAMPLE_W-1:0] acc_fin;
  logic [SAMPLE_W-1:0] word_next;
  logic                lr_edge;

  assign lr_edge = bit_rise & primed & (lr_bit != lr_last);

  always_comb begin
    acc_fin = acc;
    if (fmt == FMT_I2S && cnt != '0)
      acc_fin = put_bit(acc, 16'(cnt) - 16'd1, sd_bit);
    word_next = is_rj(fmt) ? rj_word(sr, fmt) : acc_fin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed     <= 1'b0;
      aligned    <= 1'b0;
      lr_last    <= 1'b0;
      cnt        <= '0;
      acc        <= '0;
      sr         <= '0;
      word_done  <= 1'b0;
      word_left  <= 1'b0;
      word_data  <= '0;
      word_short <= 1'b0;
    end else if (clr) begin
      primed     <= 1'b0;
      aligned    <= 1'b0;
      lr_last    <= 1'b0;
      cnt        <= '0;
      acc        <= '0;
      sr         <= '0;
      word_done  <= 1'b0;
      word_left  <= 1'b0;
      word_data  <= '0;
      word_short <= 1'b0;
    end else begin
      word_done <= 1'b0;
      if (bit_rise) begin
        primed  <= 1'b1;
        lr_last <= lr_bit;
        sr      <= {sr[SAMPLE_W-2:0], sd_bit};
        if (lr_edge) begin
          aligned    <= 1'b1;
          cnt        <= CNT_W'(1);
          acc        <= (fmt == FMT_LJ) ? put_bit('0, 16'd0, sd_bit) : '0;
          word_done  <= aligned;
          word_data  <= word_next;
          word_left  <= (lr_last == left_level(fmt));
          word_short <= (32'(cnt) < min_bits(fmt));
        end else begin
          if (cnt != '1) cnt <= cnt + CNT_W'(1);
          if (fmt == FMT_LJ)
            acc <= put_bit(acc, 16'(cnt), sd_bit);
          else if (fmt == FMT_I2S && cnt != '0)
            acc <= put_bit(acc, 16'(cnt) - 16'd1, sd_bit);
        end
      end
    end
  end

endmodule

// File: rtl/asr_rate_check.sv
module asr_rate_check
  import asr_pkg::*;
#(
  parameter int RATIO = 256,
  localparam int CW   = $clog2(RATIO + 1) + 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic frame_rise,
  output logic rate_bad
);

  logic          armed;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      cnt      <= '0;
      rate_bad <= 1'b0;
    end else if (clr) begin
      armed    <= 1'b0;
      cnt      <= '0;
      rate_bad <= 1'b0;
    end else begin
      rate_bad <= 1'b0;
      if (frame_rise) begin
        if (armed && !period_ok(32'(cnt), RATIO)) rate_bad <= 1'b1;
        armed <= 1'b1;
        cnt   <= '0;
      end else if (cnt != '1) begin
        cnt <= cnt + CW'(1);
      end
    end
  end

endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
  import asr_pkg::*;
#(
  parameter int MCLK_PER_FRAME    = 256,
  parameter int MAX_BCLK_PER_FRAME = 256,
  parameter int SYNC_STAGES       = 2,
  localparam int CNT_W            = $clog2(MAX_BCLK_PER_FRAME + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                standby,
  input  logic [1:0]          fmt_sel,
  input  logic                bclk_in,
  input  logic                lrclk_in,
  input  logic                sdata_in,
  output logic [SAMPLE_W-1:0] left_sample,
  output logic [SAMPLE_W-1:0] right_sample,
  output logic                sample_valid,
  output logic                short_frame_err,
  output logic                mclk_ratio_err
);

  logic                awake;
  fmt_e                fmt_q;
  logic                clr;
  logic [2:0]          sync_q;
  logic                sync_ready;
  logic                bclk_s, lr_s, sd_s;
  logic                bclk_d, lr_d;
  logic                bit_rise;
  logic                lr_rise;
  logic                word_done;
  logic                word_left;
  logic [SAMPLE_W-1:0] word_data;
  logic                word_short;
  logic                rate_bad;
  logic [SAMPLE_W-1:0] left_hold;
  logic                left_ok;

  // Format is taken while asleep; awake rises one cycle after release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      awake <= 1'b0;
      fmt_q <= FMT_RJ16;
    end else begin
      awake <= !standby;
      if (!awake || standby) fmt_q <= fmt_e'(fmt_sel);
    end
  end

  assign clr = !awake;

  asr_sync #(.W(3), .STAGES(SYNC_STAGES)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({sdata_in, lrclk_in, bclk_in}),
    .q     (sync_q),
    .ready (sync_ready)
  );

  assign bclk_s = sync_q[0];
  assign lr_s   = sync_q[1];
  assign sd_s   = sync_q[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_d <= 1'b0;
      lr_d   <= 1'b0;
    end else begin
      bclk_d <= bclk_s;
      lr_d   <= lr_s;
    end
  end

  assign bit_rise = sync_ready & bclk_s & ~bclk_d;
  assign lr_rise  = sync_ready & lr_s & ~lr_d;

  asr_deframer #(.CNT_W(CNT_W)) deframer_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .fmt        (fmt_q),
    .bit_rise   (bit_rise),
    .lr_bit     (lr_s),
    .sd_bit     (sd_s),
    .word_done  (word_done),
    .word_left  (word_left),
    .word_data  (word_data),
    .word_short (word_short)
  );

  asr_rate_check #(.RATIO(MCLK_PER_FRAME)) rate_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .frame_rise (lr_rise),
    .rate_bad   (rate_bad)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_hold       <= '0;
      left_ok         <= 1'b0;
      left_sample     <= '0;
      right_sample    <= '0;
      sample_valid    <= 1'b0;
      short_frame_err <= 1'b0;
      mclk_ratio_err  <= 1'b0;
    end else if (clr) begin
      left_hold       <= '0;
      left_ok         <= 1'b0;
      left_sample     <= '0;
      right_sample    <= '0;
      sample_valid    <= 1'b0;
      short_frame_err <= 1'b0;
      mclk_ratio_err  <= 1'b0;
    end else begin
      sample_valid <= 1'b0;
      if (word_done) begin
        if (word_left) begin
          left_hold <= word_data;
          left_ok   <= 1'b1;
        end else if (left_ok) begin
          left_sample  <= left_hold;
          right_sample <= word_data;
          sample_valid <= 1'b1;
          left_ok      <= 1'b0;
        end
        if (word_short) short_frame_err <= 1'b1;
      end
      if (rate_bad) mclk_ratio_err <= 1'b1;
    end
  end

endmodule

// File: rtl/asr_checks.sv
module asr_checks
  import asr_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                standby,
  input logic                awake,
  input fmt_e                fmt_q,
  input logic                word_done,
  input logic                sample_valid,
  input logic [SAMPLE_W-1:0] left_sample,
  input logic [SAMPLE_W-1:0] right_sample,
  input logic                short_frame_err,
  input logic                mclk_ratio_err
);

  AST_FMT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(awake) && !$past(standby)) |-> $stable(fmt_q)); // R1

  AST_RJ16_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && fmt_q == FMT_RJ16) |->
      (left_sample[23:16] == {8{left_sample[15]}} &&
       right_sample[23:16] == {8{right_sample[15]}})); // R4

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> !sample_valid); // R6

  AST_VALID_AFTER_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |-> $past(word_done)); // R6

  AST_SHORT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (short_frame_err && awake && !standby) |=> short_frame_err); // R7

  AST_RATIO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (mclk_ratio_err && awake && !standby) |=> mclk_ratio_err); // R8

  AST_QUIET_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!awake && !$past(awake)) |-> (!sample_valid && !short_frame_err && !mclk_ratio_err)); // R10

endmodule

bind audio_serial_rx asr_checks chk_i (
  .clk             (clk),
  .rst_n           (rst_n),
  .standby         (standby),
  .awake           (awake),
  .fmt_q           (fmt_q),
  .word_done       (word_done),
  .sample_valid    (sample_valid),
  .left_sample     (left_sample),
  .right_sample    (right_sample),
  .short_frame_err (short_frame_err),
  .mclk_ratio_err  (mclk_ratio_err)
);

// File: tb/audio_serial_rx_tb_top.sv
module audio_serial_rx_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        standby = 1'b0;
  logic [1:0]  fmt_sel = 2'b00;
  logic        bclk_in = 1'b0;
  logic        lrclk_in = 1'b0;
  logic        sdata_in = 1'b0;
  logic [23:0] left_sample, right_sample;
  logic        sample_valid, short_frame_err, mclk_ratio_err;

  always #5 clk = ~clk;

  audio_serial_rx dut_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .standby         (standby),
    .fmt_sel         (fmt_sel),
    .bclk_in         (bclk_in),
    .lrclk_in        (lrclk_in),
    .sdata_in        (sdata_in),
    .left_sample     (left_sample),
    .right_sample    (right_sample),
    .sample_valid    (sample_valid),
    .short_frame_err (short_frame_err),
    .mclk_ratio_err  (mclk_ratio_err)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int vcount = 0;
  logic [23:0] cap_l [64];
  logic [23:0] cap_r [64];
  logic i2s_prev;

  always @(negedge clk) begin
    if (sample_valid) begin
      cap_l[vcount[5:0]] <= left_sample;
      cap_r[vcount[5:0]] <= right_sample;
      vcount <= vcount + 1;
    end
  end

  // fmt, bit period in clk cycles, slots per half, left word, right word,
  // expected short flag, expected ratio flag, compare samples
  localparam int NV = 10;
  localparam int V_FMT [NV] = '{2, 3, 0, 1, 1, 2, 3, 2, 0, 3};
  localparam int V_P   [NV] = '{4, 4, 8, 4, 8, 8, 8, 5, 2, 2};
  localparam int V_N   [NV] = '{32, 32, 16, 32, 16, 16, 16, 32, 64, 64};
  localparam logic [23:0] V_L [NV] = '{24'hA5C3F1, 24'h876543, 24'h12B2C4, 24'hC0FFEE,
    24'h5A5A5A, 24'hABCDEF, 24'hF0E1D2, 24'h2468AC, 24'h008001, 24'h800001};
  localparam logic [23:0] V_R [NV] = '{24'h1234AB, 24'h0FEDCB, 24'h347FFF, 24'h13579B,
    24'h3C3C3C, 24'h135799, 24'h8899AA, 24'h7E7E7E, 24'h000123, 24'h7FFFFE};
  localparam int V_SHORT [NV] = '{0, 0, 0, 0, 1, 0, 0, 0, 0, 0};
  localparam int V_RATIO [NV] = '{0, 0, 0, 0, 0, 0, 0, 1, 0, 0};
  localparam int V_CMP   [NV] = '{1, 1, 1, 1, 0, 1, 1, 1, 1, 1};

  task automatic check_val(string tag, string what, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic string fmt_req(int fmt);
    case (fmt)
      0: return "R4";
      1: return "R5";
      2: return "R2";
      default: return "R3";
    endcase
  endfunction

  function automatic logic lr_level(int fmt, bit left);
    logic l;
    l = (fmt == 3) ? 1'b0 : 1'b1;
    return left ? l : ~l;
  endfunction

  function automatic logic [23:0] expect_word(int fmt, logic [23:0] w, int n);
    logic [23:0] m;
    if (fmt == 0) return {{8{w[15]}}, w[15:0]};
    if (fmt == 1) return w;
    m = (n >= 24) ? 24'hFFFFFF : ~(24'hFFFFFF >> n);
    return w & m;
  endfunction

  function automatic logic lj_bit(logic [23:0] w, int s);
    return (s < 24) ? w[23-s] : 1'b0;
  endfunction

  function automatic logic rj_bit(logic [23:0] w, int s, int n, int wl);
    return (s >= n - wl) ? w[n-1-s] : 1'b1;
  endfunction

  task automatic slot(logic lr, logic b, int p);
    @(negedge clk);
    lrclk_in = lr;
    sdata_in = b;
    bclk_in  = 1'b0;
    repeat (p / 2) @(negedge clk);
    bclk_in = 1'b1;
    repeat (p - p / 2 - 1) @(negedge clk);
  endtask

  task automatic half(int fmt, logic lr, logic [23:0] w, int n, int p);
    int wl;
    logic b;
    wl = (fmt == 1) ? 24 : 16;
    for (int s = 0; s < n; s++) begin
      b = (fmt <= 1) ? rj_bit(w, s, n, wl) : lj_bit(w, s);
      if (fmt == 3) begin
        slot(lr, i2s_prev, p);
        i2s_prev = b;
      end else begin
        slot(lr, b, p);
      end
    end
  endtask

  task automatic do_reset(int fmt);
    @(negedge clk);
    rst_n    = 1'b0;
    fmt_sel  = 2'(fmt);
    lrclk_in = lr_level(fmt, 1'b0);
    bclk_in  = 1'b0;
    sdata_in = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic run_vec(int fmt, int p, int n, logic [23:0] l, logic [23:0] r,
                         int exp_short, int exp_ratio, int cmp, bit rst, int pin_after,
                         string tag_in);
    int base;
    string tag;
    tag = (tag_in == "") ? fmt_req(fmt) : tag_in;
    if (rst) do_reset(fmt);
    fmt_sel  = 2'(pin_after);
    i2s_prev = 1'b0;
    base = vcount;
    half(fmt, lr_level(fmt, 1'b0), 24'h0, 4, p);
    half(fmt, lr_level(fmt, 1'b1), l, n, p);
    half(fmt, lr_level(fmt, 1'b0), r, n, p);
    half(fmt, lr_level(fmt, 1'b1), ~l, n, p);
    half(fmt, lr_level(fmt, 1'b0), ~r, n, p);
    half(fmt, lr_level(fmt, 1'b1), 24'h0, n, p);
    repeat (40) @(negedge clk);
    if (cmp != 0) begin
      check_val({tag, " R6"}, "strobe count", 24'(vcount - base), 24'd2);
      check_val(tag, "left word 1",  cap_l[base[5:0]], expect_word(fmt, l, n));
      check_val(tag, "right word 1", cap_r[base[5:0]], expect_word(fmt, r, n));
      check_val(tag, "left word 2",  cap_l[6'(base + 1)], expect_word(fmt, ~l, n));
      check_val(tag, "right word 2", cap_r[6'(base + 1)], expect_word(fmt, ~r, n));
    end
    check_val({tag, " R7"}, "short flag", 24'(short_frame_err), 24'(exp_short));
    check_val({tag, " R8"}, "ratio flag", 24'(mclk_ratio_err), 24'(exp_ratio));
  endtask

  initial begin
    int base;
    // R9: reset state
    do_reset(2);
    check_val("R9", "left after reset", left_sample, 24'h0);
    check_val("R9", "right after reset", right_sample, 24'h0);
    check_val("R9", "valid after reset", 24'(sample_valid), 24'h0);
    check_val("R9", "short after reset", 24'(short_frame_err), 24'h0);
    check_val("R9", "ratio after reset", 24'(mclk_ratio_err), 24'h0);

    // R10: constant frame clock gives no strobe
    base = vcount;
    for (int s = 0; s < 40; s++) slot(1'b0, s[0], 4);
    repeat (20) @(negedge clk);
    check_val("R10", "strobes without frame edge", 24'(vcount - base), 24'h0);

    // Table walk
    for (int v = 0; v < NV; v++)
      run_vec(V_FMT[v], V_P[v], V_N[v], V_L[v], V_R[v], V_SHORT[v], V_RATIO[v],
              V_CMP[v], 1'b1, V_FMT[v], "");

    // R1: change of fmt_sel after wake is ignored (stays left-justified)
    run_vec(2, 4, 32, 24'h6B1D93, 24'hE40257, 0, 0, 1, 1'b1, 0, "R1");

    // R10 and R1: standby clears flags, blocks strobes, takes a new format
    run_vec(1, 8, 16, 24'h111111, 24'h222222, 1, 0, 0, 1'b1, 1, "R7");
    @(negedge clk);
    standby = 1'b1;
    repeat (6) @(negedge clk);
    check_val("R10", "short during standby", 24'(short_frame_err), 24'h0);
    check_val("R10", "left during standby", left_sample, 24'h0);
    fmt_sel = 2'b11;
    base = vcount;
    for (int s = 0; s < 60; s++) slot((s / 10) % 2 == 0, s[1], 4);
    slot(1'b1, 1'b0, 4);
    repeat (10) @(negedge clk);
    check_val("R10", "strobes during standby", 24'(vcount - base), 24'h0);
    standby = 1'b0;
    repeat (6) @(negedge clk);
    run_vec(3, 4, 32, 24'h9F3C21, 24'h40A0B0, 0, 0, 1, 1'b0, 2, "R1");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule